// File: doc/BRIEF.md
# Text-Mode Character Row Serializer

This block turns a screen of character codes into the serial pixel stream of one scanline. For every character cell it reads one code from text memory, forms a glyph address from that code and the current pixel row, reads one 8-bit glyph row and shifts it out one bit per pixel clock. The output bit drives the white/black select of a two-level video DAC: 1 is white and 0 is black.

A timing generator supplies a line-start strobe, a frame-start strobe and an active-window level. At each line start the block picks the pixel row and text row for that line, points the text address at the first code of that text row and prefetches the first glyph row. During the active window it loads a new glyph row every 8 clocks and fetches the following one behind it, so the cells follow each other without a gap. Text and glyph stores are external synchronous memories with a one-cycle read latency.

Top module: `text_row_serializer`

## Requirements
- R1: During and right after reset, pixelOut, textRdEn and fontRdEn are all 0.
- R2: Every glyph read uses fontAddr = {pixel row (3 bits, upper), character code (8 bits, lower)}, so each pixel row owns a block of 256 glyph bytes.
- R3: In each line the text reads are sequential, one code per cell: the first read, issued the cycle after lineStart, is the prefetch at the text row start address, and one further read follows at the start of each cell, each address one above the last.
- R4: When activeIn first goes high no earlier than the fourth cycle after lineStart, pixelOut shows, one cycle after each active cycle, the glyph bits of consecutive cells MSB first, 8 bits per cell, with no idle clock between cells.
- R5: pixelOut is 0 in every cycle that follows a cycle with activeIn low.
- R6: While activeIn is low inside a line the text address does not advance; when the window reopens on a cell boundary the stream resumes with the next character.
- R7: The pixel row of line n within a frame is n mod 8 and the text row is n div 8; the text start address is text row × COLS.
- R8: After the last pixel row of the last text row, the following line is text row 0, pixel row 0.
- R9: frameStart returns the line count to 0; when it coincides with lineStart, that same line is pixel row 0 of text row 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStart | input | 1 | One-cycle strobe: restart the line count |
| lineStart | input | 1 | One-cycle strobe: begin a new scanline |
| activeIn | input | 1 | High during visible pixels |
| textRdEn | output | 1 | Text memory read enable |
| textAddr | output | TEXT_AW (9) | Text memory address |
| textData | input | CODE_W (8) | Character code, valid the cycle after textRdEn |
| fontRdEn | output | 1 | Glyph memory read enable |
| fontAddr | output | ROW_W+CODE_W (11) | Glyph memory address {pixel row, code} |
| fontData | input | CELL_PIX (8) | Glyph row byte, valid the cycle after fontRdEn |
| pixelOut | output | 1 | Serial white/black pixel bit |

## Verification
The cell load and the fetch of the following cell happen in the same cycle, so the shifter takes the prefetched byte while the next text read is launched; random window lengths and windows split at random cell boundaries check that no bit is lost or repeated and that the text address sequence matches. The second collision is frameStart landing on the very cycle of lineStart: the bench drives both together in the middle of a frame and expects that line to start at address 0 with pixel row 0, and the following lines to count on from there.

// File: rtl/trs_pkg.sv
package trs_pkg;

  // Per-cycle commands from the control unit to the datapath
  typedef struct packed {
    logic fetch;     // launch a text read for the next cell
    logic loadCell;  // first pixel of a cell: take the prefetched glyph row
    logic shiftBit;  // remaining pixels of a cell: shift one bit
  } trs_strobe_t;

endpackage

// File: rtl/trs_ctrl.sv
module trs_ctrl
  import trs_pkg::*;
#(
  parameter int COLS      = 64,
  parameter int TEXT_ROWS = 8,
  parameter int ROW_W     = 3,
  parameter int CELL_PIX  = 8,
  parameter int TEXT_AW   = 9
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               frameStart,
  input  logic               lineStart,
  input  logic               activeIn,
  output trs_strobe_t        strobes,
  output logic [TEXT_AW-1:0] textPtr,
  output logic [ROW_W-1:0]   curRow
);

  localparam int PH_W = (CELL_PIX > 1) ? $clog2(CELL_PIX) : 1;
  localparam int TR_W = (TEXT_ROWS > 1) ? $clog2(TEXT_ROWS) : 1;

  logic [PH_W-1:0]    phase;
  logic               prefetchPend;
  logic [ROW_W-1:0]   rowNext;
  logic [TR_W-1:0]    trNext;
  logic [TEXT_AW-1:0] baseNext;

  // Values used by the line being started (frameStart restarts them)
  logic [ROW_W-1:0]   rowSel;
  logic [TR_W-1:0]    trSel;
  logic [TEXT_AW-1:0] baseSel;
  logic               lastPixRow;
  logic               lastTextRow;

  always_comb begin
    rowSel      = frameStart ? '0 : rowNext;
    trSel       = frameStart ? '0 : trNext;
    baseSel     = frameStart ? '0 : baseNext;
    lastPixRow  = &rowSel;
    lastTextRow = (trSel == TR_W'(TEXT_ROWS - 1));
  end

  always_comb begin
    strobes.loadCell = activeIn && (phase == '0);
    strobes.shiftBit = activeIn && (phase != '0);
    strobes.fetch    = (prefetchPend || strobes.loadCell) && !lineStart;
  end

  // Line sequencing and text pointer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curRow       <= '0;
      textPtr      <= '0;
      prefetchPend <= 1'b0;
      rowNext      <= '0;
      trNext       <= '0;
      baseNext     <= '0;
    end else if (lineStart) begin
      curRow       <= rowSel;
      textPtr      <= baseSel;
      prefetchPend <= 1'b1;
      rowNext      <= rowSel + ROW_W'(1);
      if (lastPixRow) begin
        trNext   <= lastTextRow ? '0 : trSel + TR_W'(1);
        baseNext <= lastTextRow ? '0 : baseSel + TEXT_AW'(COLS);
      end else begin
        trNext   <= trSel;
        baseNext <= baseSel;
      end
    end else begin
      if (frameStart) begin
        rowNext  <= '0;
        trNext   <= '0;
        baseNext <= '0;
      end
      if (strobes.fetch) begin
        textPtr      <= textPtr + TEXT_AW'(1);
        prefetchPend <= 1'b0;
      end
    end
  end

  // Pixel position inside the current cell
  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= '0;
    end else if (activeIn) begin
      phase <= (phase == PH_W'(CELL_PIX - 1)) ? '0 : phase + PH_W'(1);
    end else begin
      phase <= '0;
    end
  end

  // R3
  fetch_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.fetch && !activeIn) |-> $past(lineStart));

  // R6
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.fetch && !lineStart) |=> $stable(textPtr));

  // R9
  frame_line0_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lineStart && frameStart) |=> (curRow == '0 && textPtr == '0));

endmodule

// File: rtl/trs_datapath.sv
module trs_datapath
  import trs_pkg::*;
#(
  parameter int ROW_W    = 3,
  parameter int CODE_W   = 8,
  parameter int CELL_PIX = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  trs_strobe_t             strobes,
  input  logic [ROW_W-1:0]        curRow,
  input  logic [CODE_W-1:0]       textData,
  input  logic [CELL_PIX-1:0]     fontData,
  output logic                    fontRdEn,
  output logic [ROW_W+CODE_W-1:0] fontAddr,
  output logic                    pixelOut
);

  logic                textVld;
  logic                fontVld;
  logic                nextValid;
  logic [CELL_PIX-1:0] nextByte;
  logic [CELL_PIX-1:0] shiftReg;

  always_comb begin
    fontRdEn = textVld;
    fontAddr = {curRow, textData};
  end

  // Fetch pipeline: text read -> glyph read -> prefetch register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      textVld   <= 1'b0;
      fontVld   <= 1'b0;
      nextValid <= 1'b0;
      nextByte  <= '0;
    end else begin
      textVld <= strobes.fetch;
      fontVld <= textVld;
      if (fontVld) begin
        nextByte  <= fontData;
        nextValid <= 1'b1;
      end else if (strobes.loadCell) begin
        nextValid <= 1'b0;
      end
    end
  end

  // Output shifter, MSB first
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      pixelOut <= 1'b0;
    end else if (strobes.loadCell) begin
      pixelOut <= nextByte[CELL_PIX-1];
      shiftReg <= {nextByte[CELL_PIX-2:0], 1'b0};
    end else if (strobes.shiftBit) begin
      pixelOut <= shiftReg[CELL_PIX-1];
      shiftReg <= {shiftReg[CELL_PIX-2:0], 1'b0};
    end else begin
      pixelOut <= 1'b0;
    end
  end

  // R2
  font_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.fetch |=> fontRdEn);

  // R5
  blank_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.loadCell && !strobes.shiftBit) |=> !pixelOut);

  // R4
  byte_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadCell |-> nextValid);

endmodule

// File: rtl/text_row_serializer.sv
module text_row_serializer
  import trs_pkg::*;
#(
  parameter int COLS      = 64,
  parameter int TEXT_ROWS = 8,
  parameter int CODE_W    = 8,
  parameter int ROW_W     = 3,
  parameter int CELL_PIX  = 8,
  localparam int TEXT_AW  = $clog2(COLS * TEXT_ROWS),
  localparam int FONT_AW  = ROW_W + CODE_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                frameStart,
  input  logic                lineStart,
  input  logic                activeIn,
  output logic                textRdEn,
  output logic [TEXT_AW-1:0]  textAddr,
  input  logic [CODE_W-1:0]   textData,
  output logic                fontRdEn,
  output logic [FONT_AW-1:0]  fontAddr,
  input  logic [CELL_PIX-1:0] fontData,
  output logic                pixelOut
);

  trs_strobe_t        strobes;
  logic [TEXT_AW-1:0] textPtr;
  logic [ROW_W-1:0]   curRow;

  trs_ctrl #(
    .COLS(COLS), .TEXT_ROWS(TEXT_ROWS), .ROW_W(ROW_W),
    .CELL_PIX(CELL_PIX), .TEXT_AW(TEXT_AW)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .lineStart(lineStart),
    .activeIn(activeIn), .strobes(strobes), .textPtr(textPtr), .curRow(curRow)
  );

  trs_datapath #(
    .ROW_W(ROW_W), .CODE_W(CODE_W), .CELL_PIX(CELL_PIX)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .curRow(curRow),
    .textData(textData), .fontData(fontData), .fontRdEn(fontRdEn),
    .fontAddr(fontAddr), .pixelOut(pixelOut)
  );

  assign textRdEn = strobes.fetch;
  assign textAddr = textPtr;

endmodule

// File: tb/text_row_serializer_tb_top.sv
`timescale 1ns/100ps
module text_row_serializer_tb_top;

  localparam int COLS      = 64;
  localparam int TEXT_ROWS = 8;
  localparam int TEXT_AW   = $clog2(COLS * TEXT_ROWS);
  localparam int TEXT_SIZE = COLS * TEXT_ROWS;
  localparam int FONT_SIZE = 8 * 256;
  localparam int FRAME_LINES = TEXT_ROWS * 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameStart = 1'b0, lineStart = 1'b0, activeIn = 1'b0;
  logic textRdEn, fontRdEn, pixelOut;
  logic [TEXT_AW-1:0] textAddr;
  logic [10:0] fontAddr;
  logic [7:0] textQ = '0, fontQ = '0;

  logic [7:0] textMem [0:TEXT_SIZE-1];
  logic [7:0] fontMem [0:FONT_SIZE-1];

  always #2.5 clk = ~clk;

  text_row_serializer dut_i (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .lineStart(lineStart),
    .activeIn(activeIn), .textRdEn(textRdEn), .textAddr(textAddr),
    .textData(textQ), .fontRdEn(fontRdEn), .fontAddr(fontAddr),
    .fontData(fontQ), .pixelOut(pixelOut)
  );

  always @(posedge clk) begin
    if (textRdEn) textQ <= textMem[textAddr];
    if (fontRdEn) fontQ <= fontMem[fontAddr];
  end

  int nChecks = 0, nFail = 0;
  bit finished = 1'b0;

  // line model state
  int lineNum = 0, expRow = 0, lineBase = 0;
  int prevIdx = -1, expAddr = 0, fetchCnt = 0, firstAddr = -1;
  int pixErr = 0, blankErr = 0, addrErr = 0, rowErr = 0;
  int badIdx = -1, badAct = 0, badExp = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic logic expPix(input int k);
    logic [7:0] code;
    logic [7:0] b;
    code = textMem[(lineBase + k / 8) % TEXT_SIZE];
    b    = fontMem[expRow * 256 + int'(code)];
    return b[7 - (k % 8)];
  endfunction

  // One clock: judge last cycle's pixel, drive this cycle, watch the reads
  task automatic cyc(input logic ls, input logic fs, input logic act, input int idx);
    logic e;
    @(negedge clk);
    e = (prevIdx >= 0) ? expPix(prevIdx) : 1'b0;
    if (pixelOut !== e) begin
      if (prevIdx >= 0) pixErr++; else blankErr++;
      if (badIdx < 0) begin badIdx = prevIdx; badAct = int'(pixelOut); badExp = int'(e); end
    end
    lineStart = ls; frameStart = fs; activeIn = act;
    #1;
    if (textRdEn) begin
      if (fetchCnt == 0) firstAddr = int'(textAddr);
      if (int'(textAddr) != expAddr) addrErr++;
      expAddr = (expAddr + 1) % TEXT_SIZE;
      fetchCnt++;
    end
    if (fontRdEn && int'(fontAddr[10:8]) != expRow) rowErr++;
    prevIdx = idx;
  endtask

  task automatic runLine(input bit fs, input int nCells, input int splitAt,
                         input int gap, input string seqTag);
    if (fs) lineNum = 0;
    expRow   = lineNum % 8;
    lineBase = ((lineNum / 8) % TEXT_ROWS) * COLS;
    pixErr = 0; blankErr = 0; addrErr = 0; rowErr = 0; badIdx = -1;
    expAddr = lineBase; fetchCnt = 0; firstAddr = -1;
    cyc(1'b1, fs, 1'b0, -1);
    repeat (4) cyc(1'b0, 1'b0, 1'b0, -1);
    for (int k = 0; k < nCells * 8; k++) begin
      if (splitAt > 0 && k == splitAt * 8)
        repeat (gap) cyc(1'b0, 1'b0, 1'b0, -1);
      cyc(1'b0, 1'b0, 1'b1, k);
    end
    repeat (4) cyc(1'b0, 1'b0, 1'b0, -1);
    lineNum = (lineNum + 1) % FRAME_LINES;
    // R4 / R6: pixel stream
    check(pixErr == 0, (splitAt > 0) ? "R6" : "R4", "pixel mismatches", pixErr, 0);
    if (pixErr != 0)
      $display("  first bad pixel %0d: got %0d want %0d", badIdx, badAct, badExp);
    // R5: blanking
    check(blankErr == 0, "R5", "non-zero pixels outside window", blankErr, 0);
    // R3: sequential text reads, one per cell plus prefetch
    check(addrErr == 0, "R3", "out-of-order text addresses", addrErr, 0);
    check(fetchCnt == nCells + 1, "R3", "text read count", fetchCnt, nCells + 1);
    // R2: glyph address upper field is the pixel row
    check(rowErr == 0, "R2", "glyph row field mismatches", rowErr, 0);
    // R7 / R8 / R9: start address of the line
    check(firstAddr == lineBase, seqTag, "line start address", firstAddr, lineBase);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < TEXT_SIZE; i++) textMem[i] = 8'($urandom);
    for (int i = 0; i < FONT_SIZE; i++) fontMem[i] = 8'($urandom);
    fontMem[0] = 8'hFF; fontMem[1] = 8'h00;
    textMem[0] = 8'h00; textMem[1] = 8'h01;

    repeat (3) @(negedge clk);
    // R1: reset state
    check(pixelOut == 1'b0, "R1", "pixelOut in reset", int'(pixelOut), 0);
    check(textRdEn == 1'b0 && fontRdEn == 1'b0, "R1", "reads in reset",
          int'(textRdEn) + int'(fontRdEn), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(pixelOut == 1'b0 && textRdEn == 1'b0, "R1", "idle after reset",
          int'(pixelOut) + int'(textRdEn), 0);

    // R9: standalone frame restart
    cyc(1'b0, 1'b1, 1'b0, -1);
    lineNum = 0;
    runLine(1'b0, 64, 0, 0, "R7");
    runLine(1'b0, 1, 0, 0, "R7");
    runLine(1'b0, 6, 3, 5, "R7");
    for (int i = 0; i < 18; i++) begin
      int n = 1 + int'($urandom % 64);
      int s = (n > 1 && ($urandom % 2) == 1) ? 1 + int'($urandom % (n - 1)) : 0;
      runLine(1'b0, n, s, 1 + int'($urandom % 9), "R7");
    end
    // R9: frame restart on the same cycle as a line start
    runLine(1'b1, 64, 0, 0, "R9");
    // R7 / R8: run through the whole frame and wrap
    for (int i = 0; i < FRAME_LINES + 2; i++) begin
      runLine(1'b0, 1 + int'($urandom % 4), 0, 0, (lineNum == 0) ? "R8" : "R7");
    end

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    finished = 1'b1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

endmodule